// File: doc/BRIEF.md
# Micro-op Queue with Admission Limits

This block is a slot-based holding queue placed between instruction decode and an out-of-order backend. Up to `LANES` instructions arrive each cycle on parallel write lanes, each with a tag and a micro-op count. An instruction occupies as many slots as it has micro-ops. The count is raised to one when it is zero and lowered to the queue depth when it is larger, so that a long microcoded instruction can still enter. Admission is decided lane by lane in program order. A lane is refused when the per-cycle instruction cap is used up or when its slots would not fit in the space that was free at the start of the cycle.

Instructions leave one at a time, in order, through a valid/ready read port. Each leaves as a whole unit that gives back all of its slots together. Slots given back by a read can be used from the following cycle. The `bypass_en` input selects one of two modes. In zero-latency mode an instruction entering an empty queue appears on the read port in the same cycle, and it is never stored if the consumer takes it. In the other mode every instruction spends at least one cycle in the queue. The `busy` output shows that slots are still held.

Top module: `uop_queue`

## Requirements
- R1: An instruction whose micro-op count exceeds `DEPTH` occupies exactly `DEPTH` slots, and `out_slots` reports `DEPTH` for it.
- R2: An instruction whose micro-op count is 0 occupies one slot, and `out_slots` reports 1 for it.
- R3: With `MAX_IPC` nonzero, lane i (lane 0 is oldest) is never ready when i >= `MAX_IPC`, so no more than `MAX_IPC` instructions enter per cycle.
- R4: With `MAX_IPC` = 0 there is no per-cycle instruction limit. All lanes can be ready in the same cycle.
- R5: Lane i is ready only if its clamped slot count, added to the slots of the accepted lanes below it, is at most `DEPTH` minus the slots held at the start of the cycle. A read in the same cycle does not add room.
- R6: Lane i > 0 is ready only when every lane below it is both valid and ready.
- R7: When `bypass_en` is 1 and the queue is empty, an accepted lane 0 is presented on the read port in the same cycle. If `out_ready` is 1 it is not stored.
- R8: When `bypass_en` is 0, an instruction written in a cycle is not visible on the read port until the next cycle.
- R9: Instructions leave in acceptance order, one per cycle when `out_valid` and `out_ready` are both 1. While `out_ready` is 0, `out_valid`, `out_tag` and `out_slots` hold steady.
- R10: `busy` is 1 exactly when at least one slot is held.
- R11: Synchronous active-high `rst` empties the queue: `busy` is 0 afterward, and `out_valid` is 0 while `bypass_en` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bypass_en | input | 1 | 1 selects zero-latency mode, 0 selects one-cycle delay |
| in_valid | input | LANES | Per-lane instruction valid, bit 0 is oldest |
| in_ready | output | LANES | Per-lane admission |
| in_tag | input | LANES*TAG_W | Lane tags, lane i at bits [i*TAG_W +: TAG_W] |
| in_uops | input | LANES*UOP_W | Lane micro-op counts, lane i at bits [i*UOP_W +: UOP_W] |
| out_valid | output | 1 | Read port holds an instruction |
| out_ready | input | 1 | Downstream takes the instruction |
| out_tag | output | TAG_W | Tag of the presented instruction |
| out_slots | output | $clog2(DEPTH+1) | Slots held by the presented instruction |
| busy | output | 1 | Slots are held |

## Verification
The properties assume only that `rst` is held for at least one clock edge. They make no assumption about the write lanes. A lane may drop `in_valid`, or change its tag or count, at any time. The lanes do not need to be contiguous. To exercise this freedom, the stimulus redraws every lane's valid bit, tag and count each cycle and keeps the consumer's ready signal random. Because the properties assume nothing about how inputs behave over time, refused lanes and gaps between lanes can appear, and the assertions stay sound under them. The bench holds `bypass_en` steady for long stretches and switches it between them, so both modes are covered with a queue that is already occupied.

// File: rtl/uop_queue.sv
module uop_queue #(
  parameter int DEPTH   = 8,
  parameter int LANES   = 3,
  parameter int MAX_IPC = 2,
  parameter int TAG_W   = 8,
  parameter int UOP_W   = 4,
  localparam int SLOT_W = $clog2(DEPTH + 1)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     bypass_en,
  input  logic [LANES-1:0]         in_valid,
  output logic [LANES-1:0]         in_ready,
  input  logic [LANES*TAG_W-1:0]   in_tag,
  input  logic [LANES*UOP_W-1:0]   in_uops,
  output logic                     out_valid,
  input  logic                     out_ready,
  output logic [TAG_W-1:0]         out_tag,
  output logic [SLOT_W-1:0]        out_slots,
  output logic                     busy
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  function automatic logic [SLOT_W-1:0] clamp_slots(input logic [UOP_W-1:0] u);
    if (u == '0) return SLOT_W'(1);
    if (int'(u) > DEPTH) return SLOT_W'(DEPTH);
    return SLOT_W'(int'(u));
  endfunction

  function automatic logic [PTR_W-1:0] wrap(input int p);
    return PTR_W'(p % DEPTH);
  endfunction

  logic [TAG_W-1:0]  tag_mem [DEPTH];
  logic [SLOT_W-1:0] len_mem [DEPTH];
  logic [PTR_W-1:0]  head, tail;
  logic [SLOT_W-1:0] n_ent, used;

  logic [SLOT_W-1:0] lane_slots [LANES];
  logic [LANES-1:0]  acc;
  int                acc_sum, push_n, push_slots;
  logic              empty_q, fwd, skip, pop;

  always_comb begin
    int   cum;
    logic ok;
    cum = 0;
    ok  = 1'b1;
    for (int i = 0; i < LANES; i++) begin
      lane_slots[i] = clamp_slots(in_uops[i*UOP_W +: UOP_W]);
      in_ready[i]   = ok && (MAX_IPC == 0 || i < MAX_IPC) &&
                      (cum + int'(lane_slots[i]) <= DEPTH - int'(used));
      acc[i]        = in_ready[i] && in_valid[i];
      if (acc[i]) cum += int'(lane_slots[i]);
      ok = acc[i];
    end
    acc_sum = cum;
  end

  assign empty_q   = (n_ent == '0);
  assign fwd       = bypass_en && empty_q && acc[0];
  assign out_valid = !empty_q || fwd;
  assign out_tag   = empty_q ? in_tag[TAG_W-1:0] : tag_mem[head];
  assign out_slots = empty_q ? lane_slots[0] : len_mem[head];
  assign pop       = out_valid && out_ready && !empty_q;
  assign skip      = fwd && out_ready;
  assign busy      = (used != '0);

  always_comb begin
    push_n     = $countones(acc) - (skip ? 1 : 0);
    push_slots = acc_sum - (skip ? int'(lane_slots[0]) : 0);
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < LANES; i++) begin
      if (acc[i] && !(i == 0 && skip)) begin
        tag_mem[wrap(int'(tail) + i - (skip ? 1 : 0))] <= in_tag[i*TAG_W +: TAG_W];
        len_mem[wrap(int'(tail) + i - (skip ? 1 : 0))] <= lane_slots[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      head  <= '0;
      tail  <= '0;
      n_ent <= '0;
      used  <= '0;
    end else begin
      head  <= pop ? wrap(int'(head) + 1) : head;
      tail  <= wrap(int'(tail) + push_n);
      n_ent <= SLOT_W'(int'(n_ent) + push_n - (pop ? 1 : 0));
      used  <= SLOT_W'(int'(used) + push_slots - (pop ? int'(len_mem[head]) : 0));
    end
  end
endmodule

// File: rtl/uop_queue_chk.sv
module uop_queue_chk #(
  parameter int DEPTH   = 8,
  parameter int LANES   = 3,
  parameter int MAX_IPC = 2,
  parameter int TAG_W   = 8,
  parameter int SLOT_W  = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              bypass_en,
  input logic [LANES-1:0]  in_valid,
  input logic [LANES-1:0]  in_ready,
  input logic              out_valid,
  input logic              out_ready,
  input logic [TAG_W-1:0]  out_tag,
  input logic [SLOT_W-1:0] out_slots,
  input logic              busy
);
  a_r1_slot_range: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_slots != '0 && int'(out_slots) <= DEPTH));

  if (MAX_IPC != 0) begin : g_cap
    a_r3_cap: assert property (@(posedge clk) disable iff (rst)
      $countones(in_ready) <= MAX_IPC);
  end

  for (genvar i = 1; i < LANES; i++) begin : g_order
    a_r6_in_order: assert property (@(posedge clk) disable iff (rst)
      in_ready[i] |-> (in_valid[i-1] && in_ready[i-1]));
  end

  a_r8_no_early: assert property (@(posedge clk) disable iff (rst)
    (!bypass_en && !busy) |-> !out_valid);

  a_r9_hold: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_tag) && $stable(out_slots)));

  a_r11_reset_empty: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !busy);
endmodule

bind uop_queue uop_queue_chk #(
  .DEPTH(DEPTH), .LANES(LANES), .MAX_IPC(MAX_IPC), .TAG_W(TAG_W), .SLOT_W(SLOT_W)
) u_chk (
  .clk(clk), .rst(rst), .bypass_en(bypass_en), .in_valid(in_valid),
  .in_ready(in_ready), .out_valid(out_valid), .out_ready(out_ready),
  .out_tag(out_tag), .out_slots(out_slots), .busy(busy)
);

// File: tb/sim_uop_queue.sv
`timescale 1ns/100ps
module sim_uop_queue;
  localparam int DEPTH = 8, LANES = 3, CAP = 2, TAG_W = 8, UOP_W = 4;
  localparam int SLOT_W = $clog2(DEPTH + 1);

  logic clk = 1'b0, rst = 1'b1, bypass_en = 1'b0, out_ready = 1'b0;
  logic [LANES-1:0] in_valid = '0;
  logic [LANES*TAG_W-1:0] in_tag = '0;
  logic [LANES*UOP_W-1:0] in_uops = '0;
  logic [LANES-1:0] in_ready, r1_ready;
  logic out_valid, busy, o1_valid, b1;
  logic [TAG_W-1:0] out_tag, t1;
  logic [SLOT_W-1:0] out_slots, s1;

  always #2.5 clk = ~clk;

  uop_queue #(.DEPTH(DEPTH), .LANES(LANES), .MAX_IPC(CAP), .TAG_W(TAG_W), .UOP_W(UOP_W)) u0 (
    .clk(clk), .rst(rst), .bypass_en(bypass_en), .in_valid(in_valid), .in_ready(in_ready),
    .in_tag(in_tag), .in_uops(in_uops), .out_valid(out_valid), .out_ready(out_ready),
    .out_tag(out_tag), .out_slots(out_slots), .busy(busy));

  uop_queue #(.DEPTH(DEPTH), .LANES(LANES), .MAX_IPC(0), .TAG_W(TAG_W), .UOP_W(UOP_W)) u1 (
    .clk(clk), .rst(rst), .bypass_en(bypass_en), .in_valid(in_valid), .in_ready(r1_ready),
    .in_tag(in_tag), .in_uops(in_uops), .out_valid(o1_valid), .out_ready(1'b1),
    .out_tag(t1), .out_slots(s1), .busy(b1));

  int n_chk = 0, n_err = 0;
  bit done = 0;
  int mtag[$], mlen[$];
  int mused;
  bit [LANES-1:0] sv;
  int st[LANES], su[LANES];
  bit sord, sbyp;

  function automatic int clampu(int u);
    if (u == 0) return 1;
    if (u > DEPTH) return DEPTH;
    return u;
  endfunction

  task automatic chk(bit ok, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  task automatic cyc(string lbl, bit c1 = 0, logic [LANES-1:0] e1 = '0);
    bit [LANES-1:0] erdy;
    int cum, sz;
    bit ok, eov;
    int etag, esl;
    @(negedge clk);
    in_valid = sv; out_ready = sord; bypass_en = sbyp;
    for (int i = 0; i < LANES; i++) begin
      in_tag[i*TAG_W +: TAG_W] = TAG_W'(st[i]);
      in_uops[i*UOP_W +: UOP_W] = UOP_W'(su[i]);
    end
    #1;
    cum = 0; ok = 1; erdy = '0;
    for (int i = 0; i < LANES; i++) begin
      if (ok && (CAP == 0 || i < CAP) && cum + clampu(su[i]) <= DEPTH - mused) erdy[i] = 1;
      if (erdy[i] && sv[i]) cum += clampu(su[i]);
      ok = erdy[i] && sv[i];
    end
    sz = mtag.size();
    eov = 0; etag = 0; esl = 0;
    if (sz > 0) begin eov = 1; etag = mtag[0]; esl = mlen[0]; end
    else if (sbyp && sv[0] && erdy[0]) begin eov = 1; etag = st[0]; esl = clampu(su[0]); end
    chk(in_ready == erdy, {lbl, " in_ready"}, int'(in_ready), int'(erdy));
    chk(out_valid == eov, {lbl, " out_valid"}, int'(out_valid), int'(eov));
    if (eov) begin
      chk(int'(out_tag) == etag, {lbl, " out_tag"}, int'(out_tag), etag);
      chk(int'(out_slots) == esl, {lbl, " out_slots"}, int'(out_slots), esl);
    end
    chk(busy == (mused != 0), {lbl, " busy"}, int'(busy), int'(mused != 0));
    if (c1) chk(r1_ready == e1, "R4 unlimited cap in_ready", int'(r1_ready), int'(e1));
    @(posedge clk);
    if (sz > 0 && sord) begin
      mused -= mlen[0];
      void'(mtag.pop_front());
      void'(mlen.pop_front());
    end
    for (int i = 0; i < LANES; i++) begin
      if (erdy[i] && sv[i] && !(i == 0 && sz == 0 && sbyp && sord)) begin
        mtag.push_back(st[i]);
        mlen.push_back(clampu(su[i]));
        mused += clampu(su[i]);
      end
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1; in_valid = '0; sv = '0; sord = 0; sbyp = 0;
    bypass_en = 0; out_ready = 0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst = 0;
    mtag.delete(); mlen.delete(); mused = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_err++;
      $display("FAIL R9 watchdog actual=%0d expected=%0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < LANES; i++) begin st[i] = 0; su[i] = 0; end
    do_reset();
    cyc("R11 after reset");
    chk(out_valid == 0, "R11 out_valid low", int'(out_valid), 0);

    sv = 3'b111; su = '{1, 1, 1}; st = '{1, 2, 3};
    cyc("R3 cap two lanes", 1, 3'b111);
    sv = '0;
    cyc("R8 visible next cycle");

    do_reset();
    sv = 3'b001; su[0] = 0; st[0] = 9;
    cyc("R8 write cycle");
    sv = '0;
    cyc("R2 zero uops");

    do_reset();
    sv = 3'b001; su[0] = 15; st[0] = 10;
    cyc("R1 clamp");
    su[0] = 1; st[0] = 11;
    cyc("R5 full refuse");
    sord = 1;
    cyc("R5 read gives no room this cycle");
    sord = 0;
    cyc("R5 room next cycle");

    do_reset();
    sv = 3'b010; su = '{1, 1, 1}; st = '{4, 5, 6};
    cyc("R6 gap below lane");

    do_reset();
    sbyp = 1; sord = 1; sv = 3'b001; su[0] = 2; st[0] = 20;
    cyc("R7 forward");
    sv = '0;
    cyc("R7 forwarded not stored");
    sord = 0; sv = 3'b001; st[0] = 21;
    cyc("R7 forward stalled");
    sv = '0;
    cyc("R9 hold under stall");
    sord = 1;
    cyc("R9 release");
    cyc("R10 empty again");

    do_reset();
    for (int n = 0; n < 4000; n++) begin
      sbyp = ((n / 250) % 2) == 1;
      sord = ($urandom_range(0, 9) < 7);
      for (int i = 0; i < LANES; i++) begin
        sv[i] = $urandom_range(0, 3) != 0;
        st[i] = int'($urandom_range(0, 255));
        su[i] = ($urandom_range(0, 15) == 0) ? 15 : int'($urandom_range(0, 3));
      end
      cyc("R9 R10 random");
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule